// File: doc/BRIEF.md
# Opcode Prefix Decoder with Refresh Counter

This block sits at the front of an 8-bit processor's instruction path. It accepts fetched instruction bytes one at a time, each qualified by a valid strobe. It sorts every instruction into one of four decode tables: base, bit-operation, extended, or indexed bit-operation. It also records which 16-bit index register, if any, replaces the HL pair in that instruction. When an instruction needs an indexed memory operand, the block takes the signed displacement byte from the stream and adds it to the selected index register value to form the operand address.

For each complete instruction the block emits one registered record: the table, the final opcode byte, the substitution code and, where one applies, the effective address. It also keeps the 7-bit-wrapping memory refresh register. That register counts opcode and prefix fetches and does not count displacement bytes. Executing the decoded operation belongs to later pipeline stages.

Top module: `opfront_top`

## Requirements
- R1: After reset `refresh` equals the parameter REFRESH_INIT (default 0x80). It advances by one for each accepted byte that is an opcode or a prefix byte (0xDD, 0xFD, 0xCB, 0xED). It does not advance for a displacement byte or for the final opcode byte of an indexed bit operation.
- R2: Only bits 6..0 of `refresh` count, wrapping from 127 to 0. Bit 7 never changes, so from 0xFF the next increment gives 0x80.
- R3: Byte 0xDD selects IX (`dec_sub` = 1) and byte 0xFD selects IY (`dec_sub` = 2). A prefix byte produces no output. When prefixes repeat, the last one decides the substitution. The byte after the prefixes is decoded in the base table (`dec_table` = 0).
- R4: The substitution is cleared once an instruction has been emitted. An instruction with no prefix reports `dec_sub` = 0.
- R5: Some base opcodes address memory through HL: 0x34, 0x35, 0x36; 0x40..0x7F where exactly one of bits 5..3 and bits 2..0 equals 6; and 0x80..0xBF with bits 2..0 = 6. With a substitution active, such an opcode takes the next byte as a signed displacement. It then emits `dec_has_ea` = 1 and `dec_ea` = index + sign-extended displacement, modulo 65536.
- R6: Byte 0xCB with no substitution active selects the bit-operation table (`dec_table` = 1). The next byte is the opcode, reported with `dec_sub` = 0.
- R7: Byte 0xCB with a substitution active is followed by the displacement and then the opcode. The block emits `dec_table` = 3 with that opcode, the substitution, and `dec_has_ea` = 1 with the effective address.
- R8: Byte 0xED selects the extended table (`dec_table` = 2) and the next byte is the opcode. Any pending substitution is dropped, so `dec_sub` = 0.
- R9: A base opcode that does not address memory through HL is emitted straight away with the active substitution and `dec_has_ea` = 0.
- R10: `dec_valid` rises in the cycle after the final byte of an instruction is accepted and stays high for one cycle per instruction. It is low during reset and in any cycle that does not follow an accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | An instruction byte is presented this cycle |
| byte_in | input | 8 | Instruction byte |
| ix_val | input | 16 | Current IX register value |
| iy_val | input | 16 | Current IY register value |
| dec_valid | output | 1 | Decoded instruction record is valid |
| dec_table | output | 2 | 0 base, 1 bit-op, 2 extended, 3 indexed bit-op |
| dec_opcode | output | 8 | Final opcode byte |
| dec_sub | output | 2 | 0 HL, 1 IX, 2 IY |
| dec_has_ea | output | 1 | `dec_ea` carries an indexed address |
| dec_ea | output | 16 | Effective address index + displacement |
| refresh | output | 8 | Refresh register |

## Verification
The assertions check three things on every cycle. Bit 7 of the refresh register never moves, and its low bits step only on fetch strobes. A bit-operation record never carries a substitution, while an indexed bit-operation record always has both a substitution and an address. A record appears only after an accepted byte. Only the bench scenarios can show the rest. These cover the byte ordering of the indexed bit-operation form, the sign extension and 16-bit wrap of the displacement add, and the rule that the last of several prefixes wins. They also cover the way an extended prefix cancels an index prefix and the exact 0xFF to 0x80 wrap of the refresh count.

// File: rtl/opfront_pkg.sv
package opfront_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 16;

    localparam logic [BYTE_W-1:0] PFX_IX  = 8'hDD;
    localparam logic [BYTE_W-1:0] PFX_IY  = 8'hFD;
    localparam logic [BYTE_W-1:0] PFX_BIT = 8'hCB;
    localparam logic [BYTE_W-1:0] PFX_EXT = 8'hED;

    typedef enum logic [1:0] {
        TBL_BASE   = 2'd0,
        TBL_BIT    = 2'd1,
        TBL_EXT    = 2'd2,
        TBL_IDXBIT = 2'd3
    } tbl_e;

    typedef enum logic [1:0] {
        SUB_NONE = 2'd0,
        SUB_IX   = 2'd1,
        SUB_IY   = 2'd2
    } sub_e;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_BIT_OPC,
        ST_EXT_OPC,
        ST_DISP,
        ST_IBIT_DISP,
        ST_IBIT_OPC
    } st_e;

    typedef struct packed {
        tbl_e              tbl;
        logic [BYTE_W-1:0] opc;
        sub_e              sub;
        logic              has_ea;
        logic [ADDR_W-1:0] ea;
    } dec_s;

    // True when a base-table opcode addresses memory through HL.
    function automatic logic uses_hl_mem(input logic [BYTE_W-1:0] op);
        logic lo6, hi6;
        lo6 = (op[2:0] == 3'd6);
        hi6 = (op[5:3] == 3'd6);
        case (op[7:6])
            2'b00:   return (op == 8'h34) || (op == 8'h35) || (op == 8'h36);
            2'b01:   return lo6 ^ hi6;
            2'b10:   return lo6;
            default: return 1'b0;
        endcase
    endfunction

    function automatic dec_s make_dec(input tbl_e t, input logic [BYTE_W-1:0] o,
                                      input sub_e s, input logic h,
                                      input logic [ADDR_W-1:0] a);
        dec_s d;
        d.tbl    = t;
        d.opc    = o;
        d.sub    = s;
        d.has_ea = h;
        d.ea     = a;
        return d;
    endfunction

endpackage

// File: rtl/opfront_ea.sv
module opfront_ea
    import opfront_pkg::*;
(
    input  sub_e              sub,
    input  logic [ADDR_W-1:0] ix_val,
    input  logic [ADDR_W-1:0] iy_val,
    input  logic [BYTE_W-1:0] disp,
    output logic [ADDR_W-1:0] ea
);
    localparam int EXT_W = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] offs;

    always_comb begin
        base = (sub == SUB_IY) ? iy_val : ix_val;
        offs = {{EXT_W{disp[BYTE_W-1]}}, disp};
        ea   = base + offs;
    end
endmodule

// File: rtl/opfront_refresh.sv
module opfront_refresh
    import opfront_pkg::*;
#(
    parameter logic [BYTE_W-1:0] REFRESH_INIT = 8'h80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    output logic [BYTE_W-1:0] r
);
    localparam int CNT_W = BYTE_W - 1;

    always_ff @(posedge clk) begin
        if (rst)
            r <= REFRESH_INIT;
        else if (inc)
            r <= {r[BYTE_W-1], r[CNT_W-1:0] + CNT_W'(1)};
    end

    // R2: the top bit is never touched by counting
    p_bit7_hold_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> r[BYTE_W-1] == $past(r[BYTE_W-1]));

    // R1: each fetch strobe steps the low bits by one
    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        inc |=> r[CNT_W-1:0] == CNT_W'($past(r[CNT_W-1:0]) + CNT_W'(1)));

    // R1: no strobe, no change
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(r));
endmodule

// File: rtl/opfront_fsm.sv
module opfront_fsm
    import opfront_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [ADDR_W-1:0] ea_in,
    output sub_e              sub_q,
    output logic              fetch_inc,
    output logic              dec_valid,
    output dec_s              dec
);
    st_e               st;
    logic [BYTE_W-1:0] held_op;
    logic [ADDR_W-1:0] held_ea;

    always_comb begin
        fetch_inc = byte_valid &&
                    (st == ST_OPC || st == ST_BIT_OPC || st == ST_EXT_OPC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_OPC;
            sub_q     <= SUB_NONE;
            held_op   <= '0;
            held_ea   <= '0;
            dec_valid <= 1'b0;
            dec       <= make_dec(TBL_BASE, '0, SUB_NONE, 1'b0, '0);
        end else begin
            dec_valid <= 1'b0;
            if (byte_valid) begin
                case (st)
                    ST_OPC: begin
                        if (byte_in == PFX_IX) begin
                            sub_q <= SUB_IX;
                        end else if (byte_in == PFX_IY) begin
                            sub_q <= SUB_IY;
                        end else if (byte_in == PFX_BIT) begin
                            st <= (sub_q == SUB_NONE) ? ST_BIT_OPC : ST_IBIT_DISP;
                        end else if (byte_in == PFX_EXT) begin
                            st    <= ST_EXT_OPC;
                            sub_q <= SUB_NONE;
                        end else if (sub_q != SUB_NONE && uses_hl_mem(byte_in)) begin
                            held_op <= byte_in;
                            st      <= ST_DISP;
                        end else begin
                            dec       <= make_dec(TBL_BASE, byte_in, sub_q, 1'b0, '0);
                            dec_valid <= 1'b1;
                            sub_q     <= SUB_NONE;
                        end
                    end
                    ST_DISP: begin
                        dec       <= make_dec(TBL_BASE, held_op, sub_q, 1'b1, ea_in);
                        dec_valid <= 1'b1;
                        sub_q     <= SUB_NONE;
                        st        <= ST_OPC;
                    end
                    ST_IBIT_DISP: begin
                        held_ea <= ea_in;
                        st      <= ST_IBIT_OPC;
                    end
                    ST_IBIT_OPC: begin
                        dec       <= make_dec(TBL_IDXBIT, byte_in, sub_q, 1'b1, held_ea);
                        dec_valid <= 1'b1;
                        sub_q     <= SUB_NONE;
                        st        <= ST_OPC;
                    end
                    ST_BIT_OPC: begin
                        dec       <= make_dec(TBL_BIT, byte_in, SUB_NONE, 1'b0, '0);
                        dec_valid <= 1'b1;
                        st        <= ST_OPC;
                    end
                    ST_EXT_OPC: begin
                        dec       <= make_dec(TBL_EXT, byte_in, SUB_NONE, 1'b0, '0);
                        dec_valid <= 1'b1;
                        st        <= ST_OPC;
                    end
                    default: st <= ST_OPC;
                endcase
            end
        end
    end

    // R6: plain bit-op records never carry a substitution or address
    p_bit_plain_r6: assert property (@(posedge clk) disable iff (rst)
        dec_valid && dec.tbl == TBL_BIT |-> dec.sub == SUB_NONE && !dec.has_ea);

    // R7: indexed bit-op records always carry both
    p_ibit_full_r7: assert property (@(posedge clk) disable iff (rst)
        dec_valid && dec.tbl == TBL_IDXBIT |-> dec.sub != SUB_NONE && dec.has_ea);

    // R4: an emitted instruction leaves no substitution behind
    p_sub_cleared_r4: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> sub_q == SUB_NONE);

    // R10: a record only follows an accepted byte
    p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
        !byte_valid |=> !dec_valid);

    // R8: extended records carry no substitution
    p_ext_plain_r8: assert property (@(posedge clk) disable iff (rst)
        dec_valid && dec.tbl == TBL_EXT |-> dec.sub == SUB_NONE);
endmodule

// File: rtl/opfront_top.sv
module opfront_top
    import opfront_pkg::*;
#(
    parameter logic [7:0] REFRESH_INIT = 8'h80
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        byte_valid,
    input  logic [7:0]  byte_in,
    input  logic [15:0] ix_val,
    input  logic [15:0] iy_val,
    output logic        dec_valid,
    output logic [1:0]  dec_table,
    output logic [7:0]  dec_opcode,
    output logic [1:0]  dec_sub,
    output logic        dec_has_ea,
    output logic [15:0] dec_ea,
    output logic [7:0]  refresh
);
    sub_e              sub_q;
    logic              fetch_inc;
    logic [ADDR_W-1:0] ea_w;
    dec_s              dec;

    opfront_ea u_ea (
        .sub    (sub_q),
        .ix_val (ix_val),
        .iy_val (iy_val),
        .disp   (byte_in),
        .ea     (ea_w)
    );

    opfront_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .ea_in      (ea_w),
        .sub_q      (sub_q),
        .fetch_inc  (fetch_inc),
        .dec_valid  (dec_valid),
        .dec        (dec)
    );

    opfront_refresh #(.REFRESH_INIT(REFRESH_INIT)) u_refresh (
        .clk (clk),
        .rst (rst),
        .inc (fetch_inc),
        .r   (refresh)
    );

    always_comb begin
        dec_table  = dec.tbl;
        dec_opcode = dec.opc;
        dec_sub    = dec.sub;
        dec_has_ea = dec.has_ea;
        dec_ea     = dec.ea;
    end
endmodule

// File: tb/opfront_top_test.sv
module opfront_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_in = '0;
    logic [15:0] ix_val = '0;
    logic [15:0] iy_val = '0;
    logic        dec_valid;
    logic [1:0]  dec_table;
    logic [7:0]  dec_opcode;
    logic [1:0]  dec_sub;
    logic        dec_has_ea;
    logic [15:0] dec_ea;
    logic [7:0]  refresh;

    int compared = 0;
    int mismatched = 0;
    logic [7:0] exp_r;

    typedef struct {
        logic [1:0]  tbl;
        logic [7:0]  opc;
        logic [1:0]  sub;
        logic        has;
        logic [15:0] ea;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    opfront_top uut (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_in(byte_in),
        .ix_val(ix_val), .iy_val(iy_val), .dec_valid(dec_valid),
        .dec_table(dec_table), .dec_opcode(dec_opcode), .dec_sub(dec_sub),
        .dec_has_ea(dec_has_ea), .dec_ea(dec_ea), .refresh(refresh)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_item(input logic [1:0] t, input logic [7:0] o, input logic [1:0] s,
                               input logic h, input logic [15:0] a, input string tag);
        item_t it;
        it.tbl = t; it.opc = o; it.sub = s; it.has = h; it.ea = a; it.tag = tag;
        sb.push_back(it);
    endtask

    // drive one byte; counts says whether it is a refresh-counted fetch (R1)
    task automatic send(input logic [7:0] b, input logic counts);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_in    = b;
        @(negedge clk);
        byte_valid = 1'b0;
        if (counts) exp_r = {exp_r[7], exp_r[6:0] + 7'd1};
        chk(refresh == exp_r, "R1 refresh count", {24'd0, refresh}, {24'd0, exp_r});
    endtask

    // monitor: compare records as they appear
    always @(negedge clk) begin
        if (!rst && dec_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R10 unexpected record", {24'd0, dec_opcode}, 32'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(dec_table == it.tbl, {it.tag, " table"}, {30'd0, dec_table}, {30'd0, it.tbl});
                chk(dec_opcode == it.opc, {it.tag, " opcode"}, {24'd0, dec_opcode}, {24'd0, it.opc});
                chk(dec_sub == it.sub, {it.tag, " sub"}, {30'd0, dec_sub}, {30'd0, it.sub});
                chk(dec_has_ea == it.has, {it.tag, " has_ea"}, {31'd0, dec_has_ea}, {31'd0, it.has});
                if (it.has)
                    chk(dec_ea == it.ea, {it.tag, " ea"}, {16'd0, dec_ea}, {16'd0, it.ea});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        exp_r = 8'h80;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1, R10 reset state
        chk(refresh == 8'h80, "R1 reset refresh", {24'd0, refresh}, 32'h80);
        chk(!dec_valid, "R10 reset valid", {31'd0, dec_valid}, 32'd0);

        // plain base opcode, no substitution (R4)
        expect_item(2'd0, 8'h00, 2'd0, 1'b0, 16'h0, "R4 base");
        send(8'h00, 1);

        // R5 indexed memory read with positive displacement
        ix_val = 16'h1000;
        expect_item(2'd0, 8'h7E, 2'd1, 1'b1, 16'h1005, "R5 ix+5");
        send(8'hDD, 1); send(8'h7E, 1); send(8'h05, 0);

        // R5 negative displacement with IY (R3)
        iy_val = 16'h2000;
        expect_item(2'd0, 8'h86, 2'd2, 1'b1, 16'h1FFE, "R5 iy-2");
        send(8'hFD, 1); send(8'h86, 1); send(8'hFE, 0);

        // R9 non-memory opcode under prefix
        expect_item(2'd0, 8'h23, 2'd1, 1'b0, 16'h0, "R9 prefixed reg op");
        send(8'hDD, 1); send(8'h23, 1);

        // R4 memory opcode without prefix takes no displacement
        expect_item(2'd0, 8'h46, 2'd0, 1'b0, 16'h0, "R4 cleared");
        send(8'h46, 1);
        expect_item(2'd0, 8'h01, 2'd0, 1'b0, 16'h0, "R4 next byte is opcode");
        send(8'h01, 1);

        // R6 bit-op table
        expect_item(2'd1, 8'h11, 2'd0, 1'b0, 16'h0, "R6 bitop");
        send(8'hCB, 1); send(8'h11, 1);

        // R8 extended table
        expect_item(2'd2, 8'hB0, 2'd0, 1'b0, 16'h0, "R8 ext");
        send(8'hED, 1); send(8'hB0, 1);

        // R7 indexed bit-op: displacement before opcode
        ix_val = 16'h0010;
        expect_item(2'd3, 8'h06, 2'd1, 1'b1, 16'hFF90, "R7 idx bitop");
        send(8'hDD, 1); send(8'hCB, 1); send(8'h80, 0); send(8'h06, 0);

        // R3 last prefix wins, R5 16-bit wrap
        iy_val = 16'hFFF0;
        expect_item(2'd0, 8'h34, 2'd2, 1'b1, 16'h006F, "R3 last prefix wins");
        send(8'hDD, 1); send(8'hFD, 1); send(8'h34, 1); send(8'h7F, 0);

        // R8 extended prefix drops pending substitution
        expect_item(2'd2, 8'h44, 2'd0, 1'b0, 16'h0, "R8 ext drops prefix");
        send(8'hDD, 1); send(8'hED, 1); send(8'h44, 1);

        // R5 store form with IY
        iy_val = 16'h3000;
        expect_item(2'd0, 8'h70, 2'd2, 1'b1, 16'h3001, "R5 store iy+1");
        send(8'hFD, 1); send(8'h70, 1); send(8'h01, 0);

        // R2 wrap: run low bits up to 0x7F then one more
        while (exp_r[6:0] != 7'h7F) begin
            expect_item(2'd0, 8'h00, 2'd0, 1'b0, 16'h0, "R2 fill");
            send(8'h00, 1);
        end
        chk(refresh == 8'hFF, "R2 top of count", {24'd0, refresh}, 32'hFF);
        expect_item(2'd0, 8'h00, 2'd0, 1'b0, 16'h0, "R2 wrap");
        send(8'h00, 1);
        chk(refresh == 8'h80, "R2 wrapped", {24'd0, refresh}, 32'h80);

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R10 records outstanding", sb.size(), 32'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule